// File: doc/BRIEF.md
# Prioritized Interrupt Event Controller

This block collects a parameterized vector of level-sensitive interrupt lines and routes them to a set of CPUs. Each line has one mask bit, one software-trigger bit and a target register that selects the CPUs it may interrupt. A source counts as pending when its input line or its software-trigger bit is high and its mask bit is clear. Each CPU has an interrupt output that stays high while any pending source is aimed at it.

A CPU services its interrupts by reading its own event register. That read returns the lowest-numbered pending source aimed at the CPU, tagged as a hardware event. The same clock edge sets that source's mask bit, so the read also acts as the acknowledge. Software runs its handler, clears the mask to re-arm the line, and keeps reading until the event register returns zero.

Configuration goes through a small register bus with separate read and write strobes. The set and clear arrays pack 32 sources per word. Read data is registered.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every software-trigger bit reads 0, every target register reads 1 (CPU 0 only), and `irq_out` is all zero.
- R2: A read of byte address 0x000 returns the number of implemented sources in bits [15:0] and zero in bits [31:16].
- R3: Source n is pending when (`irq_in[n]` OR its software bit) AND NOT its mask bit. `irq_out[c]` is high exactly when some pending source has bit c set in its target register.
- R4: Among the pending sources aimed at a CPU, the event read returns the lowest source number.
- R5: A read of the event register for CPU c (byte address 0x010 + 4*c) returns 0x0001 in bits [31:16] and the source number in bits [15:0]. On the same clock edge it sets that source's mask bit.
- R6: An event read that finds nothing pending for that CPU returns 0 and changes no mask bit.
- R7: Source n maps to word n>>5, bit n&31. Writing 1 to a bit at 0x100 + 4*word sets the mask bit and writing 1 at 0x180 + 4*word clears it. Zero bits have no effect. A read of either address returns the current mask word, with unimplemented bits reading 0.
- R8: Software-trigger bits use the same word and bit layout. Writing 1 at 0x200 + 4*word sets a bit and writing 1 at 0x280 + 4*word clears it. A read of either address returns the current word.
- R9: The target register of source n sits at 0x400 + 4*n, and bit c selects CPU c. An event read for CPU c considers only sources whose target has bit c set.
- R10: `bus_rdata` is loaded on the clock edge where `bus_rd` is sampled high and holds its value while `bus_rd` is low. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_CPU | Per-CPU interrupt request |

## Verification
A register write takes effect on the clock edge where the write strobe is sampled. `irq_out` follows combinationally from that register state and from `irq_in`, so it is sampled one falling edge after a write or an input change. Event data and the automatic mask set both land on the edge that samples the read strobe. The bench therefore holds each strobe from one falling edge to the next and samples `bus_rdata` on that second falling edge. The bench keeps its own model of the mask, software-trigger and target state, and derives each expected event word and `irq_out` value from that model.

// File: rtl/iec_pkg.sv
package iec_pkg;
   // Register word width and byte offsets of each register region.
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned OFS_INFO  = 'h000;
   localparam int unsigned OFS_EVT   = 'h010;
   localparam int unsigned OFS_MSET  = 'h100;
   localparam int unsigned OFS_MCLR  = 'h180;
   localparam int unsigned OFS_SSET  = 'h200;
   localparam int unsigned OFS_SCLR  = 'h280;
   localparam int unsigned OFS_TGT   = 'h400;
   localparam int unsigned MAX_WORDS = 32;

   // Event word type code for a hardware source.
   localparam logic [15:0] EVT_KIND_HW = 16'd1;

   // Selects the find-first structure.
   typedef enum int unsigned {
      PICK_LINEAR = 0,
      PICK_GROUPED = 1
   } pick_style_e;
endpackage

// File: rtl/iec_decode.sv
module iec_decode import iec_pkg::*; #(
   parameter int unsigned NUM_SRC   = 64,
   parameter int unsigned NUM_CPU   = 4,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr,
   input  logic                 rd,
   output logic [NUM_WORDS-1:0] mset_we,
   output logic [NUM_WORDS-1:0] mclr_we,
   output logic [NUM_WORDS-1:0] sset_we,
   output logic [NUM_WORDS-1:0] sclr_we,
   output logic [NUM_SRC-1:0]   tgt_we,
   output logic [NUM_CPU-1:0]   evt_re
);
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign mset_we[w] = wr && (addr == ADDR_W'(OFS_MSET + 4 * w));
      assign mclr_we[w] = wr && (addr == ADDR_W'(OFS_MCLR + 4 * w));
      assign sset_we[w] = wr && (addr == ADDR_W'(OFS_SSET + 4 * w));
      assign sclr_we[w] = wr && (addr == ADDR_W'(OFS_SCLR + 4 * w));
   end

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_tgt
      assign tgt_we[n] = wr && (addr == ADDR_W'(OFS_TGT + 4 * n));
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_evt
      assign evt_re[c] = rd && (addr == ADDR_W'(OFS_EVT + 4 * c));
   end
endmodule

// File: rtl/iec_src_bank.sv
module iec_src_bank import iec_pkg::*; #(
   parameter int unsigned NUM_SRC   = 64,
   parameter int unsigned NUM_CPU   = 4,
   localparam int unsigned NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [WORD_W-1:0]                 wdata,
   input  logic [NUM_WORDS-1:0]              mset_we,
   input  logic [NUM_WORDS-1:0]              mclr_we,
   input  logic [NUM_WORDS-1:0]              sset_we,
   input  logic [NUM_WORDS-1:0]              sclr_we,
   input  logic [NUM_SRC-1:0]                tgt_we,
   input  logic [NUM_SRC-1:0]                ack,
   output logic [NUM_SRC-1:0]                mask_q,
   output logic [NUM_SRC-1:0]                soft_q,
   output logic [NUM_SRC-1:0][NUM_CPU-1:0]   tgt_q
);
   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      localparam int unsigned W = n / WORD_W;
      localparam int unsigned B = n % WORD_W;

      // The acknowledge from an event read wins over a clear in the same cycle.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[n] <= 1'b1;
         end else if (ack[n] || (mset_we[W] && wdata[B])) begin
            mask_q[n] <= 1'b1;
         end else if (mclr_we[W] && wdata[B]) begin
            mask_q[n] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            soft_q[n] <= 1'b0;
         end else if (sset_we[W] && wdata[B]) begin
            soft_q[n] <= 1'b1;
         end else if (sclr_we[W] && wdata[B]) begin
            soft_q[n] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tgt_q[n] <= NUM_CPU'(1);
         end else if (tgt_we[n]) begin
            tgt_q[n] <= wdata[NUM_CPU-1:0];
         end
      end
   end
endmodule

// File: rtl/iec_pick.sv
module iec_pick import iec_pkg::*; #(
   parameter int unsigned N     = 64,
   parameter int unsigned IW    = 6,
   parameter int unsigned STYLE = PICK_GROUPED
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   if (STYLE == PICK_LINEAR) begin : g_linear
      always_comb begin
         any = |req;
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
         end
      end
   end else begin : g_grouped
      localparam int unsigned GRP = WORD_W;
      localparam int unsigned NG  = (N + GRP - 1) / GRP;

      logic [NG*GRP-1:0]   req_pad;
      logic [NG-1:0]       g_any;
      logic [NG-1:0][4:0]  g_idx;

      always_comb begin
         req_pad = '0;
         req_pad[N-1:0] = req;
      end

      // First stage: find-first inside each 32-bit group, all groups in parallel.
      for (genvar g = 0; g < NG; g++) begin : g_grp
         always_comb begin
            g_any[g] = |req_pad[g*GRP +: GRP];
            g_idx[g] = '0;
            for (int b = GRP - 1; b >= 0; b--) begin
               if (req_pad[g*GRP + b]) g_idx[g] = 5'(b);
            end
         end
      end

      // Second stage: the lowest group that has a request supplies the index.
      always_comb begin
         any = |g_any;
         idx = '0;
         for (int g = NG - 1; g >= 0; g--) begin
            if (g_any[g]) idx = IW'(g * GRP + int'(g_idx[g]));
         end
      end
   end
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl import iec_pkg::*; #(
   parameter int unsigned NUM_SRC    = 64,
   parameter int unsigned NUM_CPU    = 4,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned PICK_STYLE = PICK_GROUPED
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_in,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [31:0]         bus_wdata,
   input  logic                bus_rd,
   output logic [31:0]         bus_rdata,
   output logic [NUM_CPU-1:0]  irq_out
);
   localparam int unsigned NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
   localparam int unsigned PAD_W     = NUM_WORDS * WORD_W;
   localparam int unsigned IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   // Elaboration-time parameter checks.
   if (NUM_SRC < 1 || NUM_SRC > 65535) begin : g_bad_src
      $error("irq_event_ctrl: NUM_SRC out of range");
   end
   if (NUM_CPU < 1 || NUM_CPU > WORD_W) begin : g_bad_cpu
      $error("irq_event_ctrl: NUM_CPU out of range");
   end
   if (NUM_WORDS > MAX_WORDS) begin : g_bad_words
      $error("irq_event_ctrl: set/clear arrays overflow their regions");
   end
   if (OFS_TGT + 4 * NUM_SRC > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_event_ctrl: ADDR_W too narrow for target registers");
   end
   if (PICK_STYLE != PICK_LINEAR && PICK_STYLE != PICK_GROUPED) begin : g_bad_style
      $error("irq_event_ctrl: unknown PICK_STYLE");
   end

   logic [NUM_WORDS-1:0]             mset_we, mclr_we, sset_we, sclr_we;
   logic [NUM_SRC-1:0]               tgt_we;
   logic [NUM_CPU-1:0]               evt_re;
   logic [NUM_SRC-1:0]               mask_q, soft_q, live, ack;
   logic [NUM_SRC-1:0][NUM_CPU-1:0]  tgt_q;
   logic [NUM_CPU-1:0][NUM_SRC-1:0]  cpu_pend;
   logic [NUM_CPU-1:0]               pick_any;
   logic [NUM_CPU-1:0][IDX_W-1:0]    pick_idx;
   logic [NUM_CPU-1:0][31:0]         evt_word;
   logic [PAD_W-1:0]                 mask_pad, soft_pad;
   logic [31:0]                      rd_next;

   iec_decode #(
      .NUM_SRC (NUM_SRC),
      .NUM_CPU (NUM_CPU),
      .ADDR_W  (ADDR_W)
   ) decode_i (
      .addr    (bus_addr),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .mset_we (mset_we),
      .mclr_we (mclr_we),
      .sset_we (sset_we),
      .sclr_we (sclr_we),
      .tgt_we  (tgt_we),
      .evt_re  (evt_re)
   );

   iec_src_bank #(
      .NUM_SRC (NUM_SRC),
      .NUM_CPU (NUM_CPU)
   ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wdata   (bus_wdata),
      .mset_we (mset_we),
      .mclr_we (mclr_we),
      .sset_we (sset_we),
      .sclr_we (sclr_we),
      .tgt_we  (tgt_we),
      .ack     (ack),
      .mask_q  (mask_q),
      .soft_q  (soft_q),
      .tgt_q   (tgt_q)
   );

   assign live = (irq_in | soft_q) & ~mask_q;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      always_comb begin
         for (int n = 0; n < NUM_SRC; n++) begin
            cpu_pend[c][n] = live[n] & tgt_q[n][c];
         end
      end

      iec_pick #(
         .N     (NUM_SRC),
         .IW    (IDX_W),
         .STYLE (PICK_STYLE)
      ) pick_i (
         .req (cpu_pend[c]),
         .any (pick_any[c]),
         .idx (pick_idx[c])
      );

      assign evt_word[c] = pick_any[c] ? {EVT_KIND_HW, 16'(pick_idx[c])} : 32'd0;
      assign irq_out[c]  = pick_any[c];
   end

   // One-hot acknowledge of the source chosen by the CPU that reads its event word.
   always_comb begin
      ack = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (evt_re[c] && pick_any[c]) ack[pick_idx[c]] = 1'b1;
      end
   end

   always_comb begin
      mask_pad = '0;
      mask_pad[NUM_SRC-1:0] = mask_q;
      soft_pad = '0;
      soft_pad[NUM_SRC-1:0] = soft_q;
   end

   always_comb begin
      rd_next = '0;
      if (bus_addr == ADDR_W'(OFS_INFO)) rd_next = {16'd0, 16'(NUM_SRC)};
      for (int c = 0; c < NUM_CPU; c++) begin
         if (evt_re[c]) rd_next = evt_word[c];
      end
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (bus_addr == ADDR_W'(OFS_MSET + 4 * w) || bus_addr == ADDR_W'(OFS_MCLR + 4 * w))
            rd_next = mask_pad[w*WORD_W +: WORD_W];
         if (bus_addr == ADDR_W'(OFS_SSET + 4 * w) || bus_addr == ADDR_W'(OFS_SCLR + 4 * w))
            rd_next = soft_pad[w*WORD_W +: WORD_W];
      end
      for (int n = 0; n < NUM_SRC; n++) begin
         if (bus_addr == ADDR_W'(OFS_TGT + 4 * n)) rd_next = 32'(tgt_q[n]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_next;
      end
   end
endmodule

// File: rtl/iec_chk.sv
module iec_chk import iec_pkg::*; #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned NUM_CPU = 4,
   parameter int unsigned ADDR_W  = 12
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             bus_rd,
   input logic [ADDR_W-1:0]                bus_addr,
   input logic [31:0]                      bus_rdata,
   input logic [NUM_SRC-1:0]               mask_q,
   input logic [NUM_CPU-1:0][NUM_SRC-1:0]  cpu_pend,
   input logic [NUM_CPU-1:0]               irq_out
);
   logic                rd_evt_q;
   logic                rd_any_q;
   logic [NUM_SRC-1:0]  seen_q;
   logic [31:0]         rdata_prev;
   logic [15:0]         num;
   logic                num_ok;
   logic [NUM_SRC-1:0]  below;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_evt_q   <= 1'b0;
         rd_any_q   <= 1'b0;
         seen_q     <= '0;
         rdata_prev <= '0;
      end else begin
         rd_evt_q   <= 1'b0;
         rd_any_q   <= bus_rd;
         rdata_prev <= bus_rdata;
         for (int c = 0; c < NUM_CPU; c++) begin
            if (bus_rd && bus_addr == ADDR_W'(OFS_EVT + 4 * c)) begin
               rd_evt_q <= 1'b1;
               seen_q   <= cpu_pend[c];
            end
         end
      end
   end

   assign num    = bus_rdata[15:0];
   assign num_ok = (32'(num) < NUM_SRC);
   assign below  = num_ok ? ((NUM_SRC'(1) << num) - NUM_SRC'(1)) : '0;

   // R5: an event word is either zero or a hardware event naming a real source
   p_evt_format_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_evt_q |-> (bus_rdata == 32'd0 || (bus_rdata[31:16] == EVT_KIND_HW && num_ok)));

   // R5: the returned source is masked by the read itself
   p_evt_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_evt_q && bus_rdata != 32'd0 && num_ok) |-> mask_q[num]);

   // R4: the returned source was pending and nothing lower was pending
   p_evt_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_evt_q && bus_rdata != 32'd0 && num_ok) |-> (seen_q[num] && (seen_q & below) == '0));

   // R6: a zero event word only when nothing was pending for that CPU
   p_evt_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_evt_q && bus_rdata == 32'd0) |-> (seen_q == '0));

   // R3: with every source masked no CPU is interrupted
   p_all_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> (irq_out == '0));

   // R10: read data holds when no read was strobed
   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any_q |-> (bus_rdata == rdata_prev));
endmodule

bind irq_event_ctrl iec_chk #(
   .NUM_SRC (NUM_SRC),
   .NUM_CPU (NUM_CPU),
   .ADDR_W  (ADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .mask_q    (mask_q),
   .cpu_pend  (cpu_pend),
   .irq_out   (irq_out)
);

// File: tb/irq_event_ctrl_tb_top.sv
module irq_event_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 40;
   localparam int NC = 2;
   localparam int AW = 12;

   localparam logic [AW-1:0] A_INFO = 12'h000;
   localparam logic [AW-1:0] A_EVT  = 12'h010;
   localparam logic [AW-1:0] A_MSET = 12'h100;
   localparam logic [AW-1:0] A_MCLR = 12'h180;
   localparam logic [AW-1:0] A_SSET = 12'h200;
   localparam logic [AW-1:0] A_SCLR = 12'h280;
   localparam logic [AW-1:0] A_TGT  = 12'h400;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NS-1:0]  irq_in = '0;
   logic [AW-1:0]  bus_addr = '0;
   logic           bus_wr = 1'b0;
   logic [31:0]    bus_wdata = '0;
   logic           bus_rd = 1'b0;
   logic [31:0]    bus_rdata;
   logic [NC-1:0]  irq_out;

   int n_vec = 0;
   int n_bad = 0;
   logic finished = 1'b0;

   // Bench model of the register state, built from the requirements.
   logic [NS-1:0] m_mask;
   logic [NS-1:0] m_sw;
   logic [NC-1:0] m_tgt [NS];
   logic [31:0]   seed = 32'h1234_5679;

   irq_event_ctrl #(
      .NUM_SRC (NS),
      .NUM_CPU (NC),
      .ADDR_W  (AW)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   function automatic logic [31:0] exp_evt(input int c);
      for (int n = 0; n < NS; n++) begin
         if ((irq_in[n] || m_sw[n]) && !m_mask[n] && m_tgt[n][c]) return {16'd1, 16'(n)};
      end
      return 32'd0;
   endfunction

   function automatic logic [NC-1:0] exp_irq();
      logic [NC-1:0] r = '0;
      for (int c = 0; c < NC; c++) begin
         if (exp_evt(c) != 32'd0) r[c] = 1'b1;
      end
      return r;
   endfunction

   function automatic logic [31:0] word_of(input logic [NS-1:0] v, input int w);
      logic [31:0] r = '0;
      for (int b = 0; b < 32; b++) begin
         if (w * 32 + b < NS) r[b] = v[w * 32 + b];
      end
      return r;
   endfunction

   // Register write; the model follows the address map of R7, R8 and R9.
   task automatic mwrite(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      for (int w = 0; w < 2; w++) begin
         for (int b = 0; b < 32; b++) begin
            if (w * 32 + b < NS && d[b]) begin
               if (a == A_MSET + AW'(4 * w)) m_mask[w * 32 + b] = 1'b1;
               if (a == A_MCLR + AW'(4 * w)) m_mask[w * 32 + b] = 1'b0;
               if (a == A_SSET + AW'(4 * w)) m_sw[w * 32 + b] = 1'b1;
               if (a == A_SCLR + AW'(4 * w)) m_sw[w * 32 + b] = 1'b0;
            end
         end
      end
      for (int n = 0; n < NS; n++) begin
         if (a == A_TGT + AW'(4 * n)) m_tgt[n] = d[NC-1:0];
      end
   endtask

   task automatic mread(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   // Event read for CPU c, checked against the model (R4, R5, R6, R9).
   task automatic evt_read(input int c, input string req, output logic [31:0] got);
      logic [31:0] exp = exp_evt(c);
      mread(A_EVT + AW'(4 * c), got);
      check(req, got, exp);
      if (exp != 32'd0) m_mask[exp[15:0]] = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      m_mask = '1;
      m_sw = '0;
      for (int n = 0; n < NS; n++) m_tgt[n] = NC'(1);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 irq_out", 32'(irq_out), 32'd0);
      mread(A_MSET, d);      check("R1 mask word0", d, 32'hFFFF_FFFF);
      mread(A_MCLR + 4, d);  check("R1 mask word1", d, 32'h0000_00FF);
      mread(A_SSET, d);      check("R1 soft word0", d, 32'd0);
      mread(A_SCLR + 4, d);  check("R1 soft word1", d, 32'd0);
      mread(A_TGT + 4 * 7, d); check("R1 target 7", d, 32'd1);
      // R2: info register
      mread(A_INFO, d);      check("R2 info", d, 32'd40);
      // R10: unmapped address reads zero
      mread(12'h0F0, d);     check("R10 unmapped", d, 32'd0);

      // R6: lines high but all masked -> empty event, mask unchanged
      irq_in = '1;
      @(negedge clk);
      check("R3 masked irq_out", 32'(irq_out), 32'd0);
      evt_read(0, "R6 empty read", d);
      check("R6 empty value", d, 32'd0);
      mread(A_MSET, d);      check("R6 mask unchanged", d, 32'hFFFF_FFFF);
      irq_in = '0;

      // Per-source sweep: R3, R5, R7, R9
      for (int n = 0; n < NS; n++) begin
         irq_in = NS'(1) << n;
         @(negedge clk);
         check("R3 masked source", 32'(irq_out), 32'd0);
         mwrite(A_MCLR + AW'(4 * (n / 32)), 32'd1 << (n % 32));
         check("R3 irq_out cpu0", 32'(irq_out), 32'd1);
         evt_read(1, "R9 other cpu empty", d);
         check("R9 other cpu value", d, 32'd0);
         evt_read(0, "R5 event", d);
         check("R5 event value", d, {16'd1, 16'(n)});
         check("R5 irq_out after ack", 32'(irq_out), 32'd0);
         mread(A_MSET + AW'(4 * (n / 32)), d);
         check("R7 mask re-set", d, (n < 32) ? 32'hFFFF_FFFF : 32'h0000_00FF);
         evt_read(0, "R6 after ack", d);
      end
      irq_in = '0;

      // Priority and routing: odd sources to CPU 1 (R4, R9)
      for (int n = 1; n < NS; n += 2) mwrite(A_TGT + AW'(4 * n), 32'd2);
      mread(A_TGT + 4 * 5, d); check("R9 target readback", d, 32'd2);
      mwrite(A_MCLR, 32'hFFFF_FFFF);
      mwrite(A_MCLR + 4, 32'hFFFF_FFFF);
      mwrite(A_MSET, 32'd0);
      mread(A_MSET, d);      check("R7 zero write ignored", d, 32'd0);
      irq_in = '1;
      @(negedge clk);
      check("R3 both cpus", 32'(irq_out), 32'd3);
      for (int k = 0; k < NS; k += 2) begin
         evt_read(0, "R4 even order", d);
         check("R4 even value", d, {16'd1, 16'(k)});
      end
      evt_read(0, "R6 cpu0 drained", d);
      check("R3 cpu1 only", 32'(irq_out), 32'd2);
      for (int k = 1; k < NS; k += 2) begin
         evt_read(1, "R4 odd order", d);
         check("R4 odd value", d, {16'd1, 16'(k)});
      end
      evt_read(1, "R6 cpu1 drained", d);
      check("R3 all acked", 32'(irq_out), 32'd0);
      irq_in = '0;

      // Software trigger: R8
      mwrite(A_MCLR, 32'hFFFF_FFFF);
      mwrite(A_MCLR + 4, 32'hFFFF_FFFF);
      check("R3 idle unmasked", 32'(irq_out), 32'd0);
      mwrite(A_SSET + 4, 32'h0000_00A5);
      mwrite(A_SCLR + 4, 32'h0000_0004);
      mread(A_SSET + 4, d);  check("R8 soft word1", d, 32'h0000_00A1);
      evt_read(0, "R8 soft cpu0", d);
      check("R8 soft value", d, {16'd1, 16'd32});
      evt_read(0, "R8 soft cpu0 drained", d);
      evt_read(1, "R8 soft cpu1 first", d);
      check("R8 soft cpu1 value", d, {16'd1, 16'd37});
      evt_read(1, "R8 soft cpu1 second", d);
      check("R8 soft cpu1 value2", d, {16'd1, 16'd39});

      // R10: read data holds while idle
      mread(A_INFO, d);
      repeat (3) @(negedge clk);
      check("R10 hold", bus_rdata, 32'd40);

      // Mixed sweep against the model: R3, R4, R5, R7, R8, R9
      for (int it = 0; it < 400; it++) begin
         logic [31:0] r = rnd();
         logic [31:0] v = rnd();
         int w = int'(r[8]);
         irq_in = {r[31:24], rnd()} & {8'hFF, rnd()};
         case (r % 6)
            0: mwrite(A_MCLR + AW'(4 * w), v);
            1: mwrite(A_MSET + AW'(4 * w), v & rnd());
            2: mwrite(A_SSET + AW'(4 * w), v & rnd() & rnd());
            3: mwrite(A_SCLR + AW'(4 * w), v);
            4: mwrite(A_TGT + AW'(4 * (v % NS)), 32'(r[17:16]));
            default: @(negedge clk);
         endcase
         @(negedge clk);
         check("R3 mixed irq_out", 32'(irq_out), 32'(exp_irq()));
         evt_read(int'(r[20]), "R4 mixed event", d);
         mread(A_MSET + AW'(4 * w), d);
         check("R7 mixed mask", d, word_of(m_mask, w));
         mread(A_SCLR + AW'(4 * w), d);
         check("R8 mixed soft", d, word_of(m_sw, w));
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule